// File: doc/BRIEF.md
# Delayed Trigger Counter Unit

This block holds back a trigger event for a programmable number of trace output words and then signals it downstream. An 8-bit count gives the base delay in words. A five-bit multiplier select scales that count by powers of two. When a trigger is accepted, the block computes the full delay once and loads it into a countdown. The countdown steps only on cycles where the word-output strobe is high. When it runs out, the block sends a one-cycle delayed trigger pulse and raises a sticky completion flag.

Software programs the count and the multiplier through a small synchronous register port, and reads back two status bits: one for a countdown in progress, one for a completed trigger. Only one trigger is handled at a time. Triggers that arrive while a countdown runs, or before software has cleared the completion flag, have no effect.

Top module: `trig_delay_unit`

## Requirements
- R1: After reset, `trig_o`, `running_o` and `fired_o` are low, and every register address reads 0.
- R2: Register map (8-bit data). Address 0 holds the count (bits 7:0). Address 1 holds the multiplier select in bits 4:0, and bits 7:5 read 0. Address 2 reads the status: bit 0 is running, bit 1 is fired. Address 3 reads 0.
- R3: The delay of an accepted trigger is the count times the product of the factors of the set select bits. Select bit i contributes 2^(i+1), and with no bit set the factor is 1. `trig_o` goes high in the cycle after the clock edge that sampled the strobe that completes the delay.
- R4: `running_o` rises in the cycle after a trigger with a non-zero delay is accepted. It stays high until the countdown completes, and it is never high together with `fired_o`.
- R5: `trig_o` is a single-cycle pulse, and `fired_o` is high in the same cycle.
- R6: With a count of 0, for any multiplier, `trig_o` and `fired_o` go high in the cycle after the trigger, and `running_o` stays low.
- R7: `fired_o` holds until a write to address 2 with bit 1 set. A trigger is accepted only when both flags are low, so triggers during a countdown, while fired, or in the cycle of the clearing write are ignored.
- R8: Writes to the count or multiplier during a countdown do not change the delay already in flight. They apply from the next accepted trigger.
- R9: A word strobe that comes outside a countdown (idle, fired, or in the cycle the trigger is accepted) has no effect on the delay or the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger event pulse |
| word_i | input | 1 | Word-output strobe, one per word sent |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| trig_o | output | 1 | Delayed trigger pulse |
| running_o | output | 1 | Trigger seen, countdown not finished |
| fired_o | output | 1 | Countdown finished, trigger delivered |

## Verification
The bench sweeps all 32 multiplier combinations and a range of counts, with steady and gapped strobe patterns. It counts the strobes up to the pulse and compares the count with the arithmetic product. A scaler that uses 2^i instead of 2^(i+1), or that adds factors instead of multiplying them, misses by a multiple. A countdown that counts idle cycles fires early under gapped strobes. A design that counts the strobe in the trigger cycle fires one word short.

A count of 0 checks the immediate-fire path, where a plain decrement would wrap and stall for millions of words. Further runs re-trigger and rewrite the count mid-flight, and trigger during the clear-write cycle. A design that restarts, reloads or re-arms shows a wrong delay or a stray pulse.

// File: rtl/tdu_pkg.sv
`timescale 1ns/1ps
package tdu_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] A_MULT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;

  localparam int unsigned ST_RUN   = 0;
  localparam int unsigned ST_FIRED = 1;

  typedef struct packed {
    logic fired;
    logic running;
  } tdu_stat_t;
endpackage

// File: rtl/tdu_regs.sv
`timescale 1ns/1ps
module tdu_regs
  import tdu_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned MUL_N  = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  tdu_stat_t         stat_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [MUL_N-1:0]  mult_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CNT_W-1:0] count_q;
  logic [MUL_N-1:0] mult_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      mult_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_COUNT) count_q <= wdata_i[CNT_W-1:0];
      if (addr_i == A_MULT)  mult_q  <= wdata_i[MUL_N-1:0];
    end
  end

  // status clear is a strobe, not a stored bit
  assign clr_o = we_i && (addr_i == A_STAT) && wdata_i[ST_FIRED];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_COUNT: rdata_o[CNT_W-1:0] = count_q;
      A_MULT:  rdata_o[MUL_N-1:0] = mult_q;
      A_STAT: begin
        rdata_o[ST_RUN]   = stat_i.running;
        rdata_o[ST_FIRED] = stat_i.fired;
      end
      default: rdata_o = '0;
    endcase
  end

  assign count_o = count_q;
  assign mult_o  = mult_q;
endmodule

// File: rtl/tdu_scale.sv
`timescale 1ns/1ps
module tdu_scale #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned MUL_N = 5,
  parameter int unsigned DLY_W = CNT_W + MUL_N * (MUL_N + 1) / 2
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [MUL_N-1:0] mult_i,
  output logic [DLY_W-1:0] delay_o,
  output logic             zero_o
);
  logic [MUL_N:0][DLY_W-1:0] stage;

  assign stage[0] = DLY_W'(count_i);

  // select bit i multiplies by 2^(i+1); stages chain so factors multiply
  for (genvar gi = 0; gi < MUL_N; gi++) begin : g_stage
    localparam int unsigned SH = gi + 1;
    assign stage[gi+1] = mult_i[gi] ? (stage[gi] << SH) : stage[gi];
  end

  assign delay_o = stage[MUL_N];
  // shifts are lossless at DLY_W, so zero only when the count is zero
  assign zero_o  = (count_i == '0);
endmodule

// File: rtl/tdu_countdown.sv
`timescale 1ns/1ps
module tdu_countdown #(
  parameter int unsigned DLY_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             word_i,
  input  logic             clr_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             zero_i,
  output logic             pulse_o,
  output logic             running_o,
  output logic             fired_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             run_q, fired_q, pulse_q;
  logic             last_word;

  assign last_word = word_i && (cnt_q == DLY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (run_q) begin
        if (last_word) begin
          cnt_q   <= '0;
          run_q   <= 1'b0;
          fired_q <= 1'b1;
          pulse_q <= 1'b1;
        end else if (word_i) begin
          cnt_q <= cnt_q - DLY_W'(1);
        end
      end else if (fired_q) begin
        if (clr_i) fired_q <= 1'b0;
      end else if (trig_i) begin
        if (zero_i) begin
          fired_q <= 1'b1;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= delay_i;
          run_q <= 1'b1;
        end
      end
    end
  end

  assign pulse_o   = pulse_q;
  assign running_o = run_q;
  assign fired_o   = fired_q;
endmodule

// File: rtl/trig_delay_unit.sv
`timescale 1ns/1ps
module trig_delay_unit
  import tdu_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned MUL_N  = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              word_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              trig_o,
  output logic              running_o,
  output logic              fired_o
);
  localparam int unsigned DLY_W = CNT_W + MUL_N * (MUL_N + 1) / 2;

  logic [CNT_W-1:0] count;
  logic [MUL_N-1:0] mult;
  logic [DLY_W-1:0] delay;
  logic             delay_zero;
  logic             stat_clr;
  tdu_stat_t        stat;

  tdu_regs #(.CNT_W(CNT_W), .MUL_N(MUL_N), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat),
    .count_o (count),
    .mult_o  (mult),
    .clr_o   (stat_clr),
    .rdata_o (reg_rdata_o)
  );

  tdu_scale #(.CNT_W(CNT_W), .MUL_N(MUL_N), .DLY_W(DLY_W)) u_scale (
    .count_i (count),
    .mult_i  (mult),
    .delay_o (delay),
    .zero_o  (delay_zero)
  );

  tdu_countdown #(.DLY_W(DLY_W)) u_cd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .word_i    (word_i),
    .clr_i     (stat_clr),
    .delay_i   (delay),
    .zero_i    (delay_zero),
    .pulse_o   (trig_o),
    .running_o (running_o),
    .fired_o   (fired_o)
  );

  assign stat.running = running_o;
  assign stat.fired   = fired_o;
endmodule

// File: rtl/tdu_checker.sv
`timescale 1ns/1ps
module tdu_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic trig_i,
  input logic word_i,
  input logic clr_i,
  input logic trig_o,
  input logic running_o,
  input logic fired_o
);
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r5_pulse_with_fired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (fired_o && !running_o));

  a_r4_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(running_o && fired_o));

  a_r3_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !word_i) |=> (running_o && !trig_o));

  a_r3_end_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) |-> ($past(word_i) && trig_o));

  a_r7_fired_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_o && !clr_i) |=> fired_o);

  a_r7_no_start_from_fired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired_o |=> !running_o);

  a_r7_start_needs_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> $past(trig_i));
endmodule

bind trig_delay_unit tdu_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trig_i    (trig_i),
  .word_i    (word_i),
  .clr_i     (stat_clr),
  .trig_o    (trig_o),
  .running_o (running_o),
  .fired_o   (fired_o)
);

// File: tb/trig_delay_unit_tb.sv
`timescale 1ns/1ps
module trig_delay_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic       word = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       trig_o, running, fired;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trig_delay_unit u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .trig_i      (trig),
    .word_i      (word),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .trig_o      (trig_o),
    .running_o   (running),
    .fired_o     (fired)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic longint exp_delay(input int cnt, input logic [4:0] m);
    longint f = 1;
    for (int i = 0; i < 5; i++) if (m[i]) f = f * (longint'(1) << (i + 1));
    return longint'(cnt) * f;
  endfunction

  // one trigger; gap adds idle strobe cycles; disturb re-triggers and rewrites count mid-run
  task automatic run(input int cnt, input logic [4:0] m, input bit gap, input bit disturb);
    longint d = exp_delay(cnt, m);
    longint got = 0;
    int     early = 0;
    int     k = 0;
    logic [7:0] r;
    bit     w;
    wr(2'd0, 8'(cnt));
    wr(2'd1, 8'(m));
    trig = 1'b1; word = 1'b1;       // strobe in accept cycle must not count (R9)
    @(negedge clk);
    trig = 1'b0; word = 1'b0;
    if (d == 0) begin
      chk(trig_o && fired && !running, "R6", "zero-count pulse", {trig_o, fired, running}, 3'b110);
    end else begin
      chk(running && !trig_o && !fired, "R4", "running after accept", {trig_o, fired, running}, 3'b001);
      while (got < d) begin
        w = gap ? ((k % 3) != 1) : 1'b1;
        word = w;
        if (disturb && k == 2) begin
          trig = 1'b1; we = 1'b1; addr = 2'd0; wdata = 8'hFF;
        end
        @(negedge clk);
        trig = 1'b0; we = 1'b0; wdata = '0;
        if (w) got++;
        if (got < d && (trig_o || !running || fired)) early++;
        k++;
      end
      word = 1'b0;
      chk(early == 0, "R3", "no early end of countdown", early, 0);
      chk(trig_o && fired && !running, "R3", $sformatf("pulse after %0d words (cnt %0d mult %0d)", d, cnt, m),
          {trig_o, fired, running}, 3'b110);
      if (disturb) begin
        rd(2'd0, r);
        chk(r == 8'hFF, "R8", "mid-run count write stored", r, 8'hFF);
      end
    end
    @(negedge clk);
    chk(!trig_o && fired, "R5", "pulse one cycle, fired held", {trig_o, fired}, 2'b01);
    wr(2'd2, 8'h02);
    chk(!fired && !running, "R7", "clear write drops fired", {fired, running}, 2'b00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!trig_o && !running && !fired, "R1", "outputs at reset", {trig_o, running, fired}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk(r == 0, "R1", $sformatf("reg %0d at reset", a), r, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register map
    wr(2'd0, 8'hA5); rd(2'd0, r); chk(r == 8'hA5, "R2", "count readback", r, 8'hA5);
    wr(2'd1, 8'hFF); rd(2'd1, r); chk(r == 8'h1F, "R2", "mult readback", r, 8'h1F);
    wr(2'd3, 8'hFF); rd(2'd3, r); chk(r == 8'h00, "R2", "unused address", r, 0);
    rd(2'd2, r); chk(r == 8'h00, "R2", "status idle", r, 0);

    // R9 strobes while idle
    wr(2'd0, 8'd1); wr(2'd1, 8'd0);
    word = 1'b1; repeat (5) @(negedge clk); word = 1'b0;
    chk(!trig_o && !running && !fired, "R9", "idle strobes inert", {trig_o, running, fired}, 0);

    // R6 zero count with every multiplier
    for (int m = 0; m < 32; m++) run(0, 5'(m), 1'b0, 1'b0);

    // R3 every multiplier combination at count 1
    for (int m = 0; m < 32; m++) run(1, 5'(m), 1'b0, 1'b0);

    // R3 count sweep, steady and gapped strobes
    for (int c = 1; c <= 12; c++) run(c, 5'd0, 1'b1, 1'b0);
    for (int c = 1; c <= 6; c++) run(c, 5'b00001, 1'b1, 1'b0);
    run(255, 5'd0, 1'b0, 1'b0);
    run(255, 5'b10000, 1'b1, 1'b0);
    run(3, 5'b00101, 1'b1, 1'b0);

    // R8 and R7: retrigger and count rewrite during countdown
    run(3, 5'b00011, 1'b1, 1'b1);

    // R2 status readback while running and fired
    wr(2'd0, 8'd2); wr(2'd1, 8'd0);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    rd(2'd2, r); chk(r == 8'h01, "R2", "status running", r, 1);
    word = 1'b1; repeat (2) @(negedge clk); word = 1'b0;
    rd(2'd2, r); chk(r == 8'h02, "R2", "status fired", r, 2);

    // R7/R9 trigger and strobes while fired are ignored
    trig = 1'b1; word = 1'b1; @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk); word = 1'b0;
    chk(fired && !running && !trig_o, "R7", "trigger while fired ignored", {fired, running, trig_o}, 3'b100);

    // R7 trigger in clearing cycle ignored
    trig = 1'b1; wr(2'd2, 8'h02); trig = 1'b0;
    @(negedge clk);
    chk(!fired && !running && !trig_o, "R7", "trigger in clear cycle ignored", {fired, running, trig_o}, 0);

    // R7 clear write with bit1 low does nothing
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    word = 1'b1; repeat (2) @(negedge clk); word = 1'b0;
    wr(2'd2, 8'h01);
    chk(fired, "R7", "clear without bit1 keeps fired", fired, 1);
    wr(2'd2, 8'h02);

    // R1 asynchronous reset mid-run
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    rst_n = 1'b0; #1;
    chk(!running && !fired && !trig_o, "R1", "reset mid-run", {running, fired, trig_o}, 0);
    rd(2'd0, r); chk(r == 0, "R1", "count cleared by reset", r, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule